// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Sequencer

This block is the register-mapped digital side of a multi-channel analog-to-digital converter. Software selects channels by writing their control bytes. It sets the pacing divider and turns the module on through a configuration byte. The block then walks the enabled channels one after another. Before each conversion it waits a fixed sample delay plus a divider-scaled conversion time. It then asks an external converter for a result through a request/acknowledge handshake.

Each returned 10-bit result is split into a high and a low data byte for its channel, and the channel's data-valid flag is set. Software clears that flag by writing 1, either in one of two status bytes or in bit 7 of the channel's control byte. An optional hold mode freezes a channel's data bytes while its flag is set. A level interrupt stays high while any enabled channel with its interrupt enable set has a pending result.

There are twelve channel slots. Slots 0 to 7 carry logical channel numbers 0 to 7, and slots 8 to 11 carry logical numbers 13 to 16.

Top module: `adc_fe_top`

## Requirements
- R1: After reset every register reads 0x00, with one exception: the control bytes of slots 0 to 3 read 0x1F. `irq` and `conv_req` are low.
- R2: Slots 0 to 3 are selected only when control bits 4:0 equal the slot's own index. Any other value in that field, such as 0x1F or another slot's index, leaves the slot unselected.
- R3: Slots 4 to 11 are selected by control bit 4. While `conv_req` is high, `conv_chan` shows the logical channel: the slot number for slots 0 to 7, and slot+5 for slots 8 to 11.
- R4: Configuration byte (address 0x00) bit 0 enables the module. No request is raised while it is 0, even with channels selected.
- R5: After an acknowledged request, `conv_req` stays low for exactly SAMPLE_CYC + (DIV+1)*BASE_CYC cycles before the next request. DIV is the 6-bit field at address 0x01, bits 5:0.
- R6: Selected channels are serviced in ascending slot order and wrap from the highest back to the lowest. The first conversion after reset uses the lowest selected slot.
- R7: An accepted result for slot s appears at address 0x10+2s as bits 1:0 = result[9:8] (upper bits 0), and at address 0x11+2s as result[7:0]. The control byte at 0x04+s then reads bit 7 = 1.
- R8: A write of 1 to a status bit, or a control-byte write with bit 7 set, clears that slot's valid flag. Bits written as 0 leave the flags unchanged.
- R9: With configuration bit 1 (hold) set, a slot's data bytes do not change while its valid flag is set. With hold clear, each new result overwrites them.
- R10: `irq` is high exactly while some selected slot has both its valid flag and its control bit 5 (interrupt enable) set. It stays high until that flag is cleared or the enable or selection is removed.
- R11: Status byte 0x02 holds the valid flags of slots 0 to 7 in bits 0 to 7. Status byte 0x03 holds those of slots 8 to 11 (channels 13 to 16) in bits 0 to 3.
- R12: `conv_req` stays high, with `conv_chan` stable, until `conv_ack` is seen. The result is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 5 | Logical channel number of the request |
| conv_ack | input | 1 | Converter result valid this cycle |
| conv_result | input | 10 | Converter result |
| irq | output | 1 | Level interrupt |

## Verification
Register writes take effect on the clock edge that ends the write cycle. A flag, data byte or `irq` change caused by an acknowledge can be seen at the next falling edge. The bench drives on falling edges and reads registers one picosecond later, so every value it compares is settled. Conversion spacing is measured by counting falling-edge samples with `conv_req` low between two requests. Each divider value is measured on the second gap after the write, so the figure always comes from a load that used the new divider. Checks on frozen or cleared data are made after the module is switched off, when no further acknowledge can land.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

    localparam int NCH        = 12;   // channel slots
    localparam int NLOW       = 4;    // slots using index-encoded select
    localparam int NSTAT_A    = 8;    // slots reported in first status byte
    localparam int HIGH_BASE  = 13;   // logical number of slot NSTAT_A
    localparam int RES_W      = 10;
    localparam int DIV_W      = 6;
    localparam int ADDR_W     = 6;
    localparam int CHAN_W     = 5;
    localparam int SLOT_W     = $clog2(NCH);

    localparam int A_CFG      = 0;
    localparam int A_DIV      = 1;
    localparam int A_STA      = 2;
    localparam int A_STB      = 3;
    localparam int A_CTRL0    = 4;
    localparam int A_DATA0    = 16;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_REQ
    } sched_st_e;

    typedef struct packed {
        logic              fire;
        logic [SLOT_W-1:0] slot;
        logic [RES_W-1:0]  value;
    } conv_res_t;

    function automatic logic [CHAN_W-1:0] slot_chan(input logic [SLOT_W-1:0] slot);
        if (int'(slot) < NSTAT_A)
            return CHAN_W'(slot);
        return CHAN_W'(int'(slot) - NSTAT_A + HIGH_BASE);
    endfunction

    // first selected slot strictly after cur, wrapping around
    function automatic logic [SLOT_W-1:0] next_slot(input logic [NCH-1:0] en,
                                                    input logic [SLOT_W-1:0] cur);
        logic [SLOT_W-1:0] pick;
        logic              found;
        pick  = cur;
        found = 1'b0;
        for (int i = 1; i <= NCH; i++) begin
            int cand;
            cand = (int'(cur) + i) % NCH;
            if (!found && en[cand]) begin
                pick  = SLOT_W'(cand);
                found = 1'b1;
            end
        end
        return pick;
    endfunction

endpackage

// File: rtl/adc_fe_sched.sv
module adc_fe_sched
    import adc_fe_pkg::*;
#(
    parameter int BASE_CYC   = 4,
    parameter int SAMPLE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mod_en,
    input  logic [NCH-1:0]    chan_en,
    input  logic [DIV_W-1:0]  div,
    input  logic              conv_ack,
    output logic              conv_req,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [SLOT_W-1:0] cur_slot
);
    localparam int MAX_WAIT = SAMPLE_CYC + (1 << DIV_W) * BASE_CYC;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    sched_st_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [SLOT_W-1:0] cur;
    logic [SLOT_W-1:0] last;
    logic [CNT_W-1:0]  load_val;

    assign load_val = CNT_W'(SAMPLE_CYC) + (CNT_W'(div) + CNT_W'(1)) * CNT_W'(BASE_CYC)
                    - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cnt   <= '0;
            cur   <= '0;
            last  <= SLOT_W'(NCH - 1);
        end else if (!mod_en) begin
            state <= S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: if (|chan_en) begin
                    cur   <= next_slot(chan_en, last);
                    cnt   <= load_val;
                    state <= S_WAIT;
                end
                S_WAIT: begin
                    if (cnt == '0) state <= S_REQ;
                    else           cnt   <= cnt - CNT_W'(1);
                end
                S_REQ: if (conv_ack) begin
                    last <= cur;
                    if (|chan_en) begin
                        cur   <= next_slot(chan_en, cur);
                        cnt   <= load_val;
                        state <= S_WAIT;
                    end else begin
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign conv_req  = (state == S_REQ);
    assign conv_chan = slot_chan(cur);
    assign cur_slot  = cur;
endmodule

// File: rtl/adc_fe_regs.sv
module adc_fe_regs
    import adc_fe_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [7:0]                  wdata,
    input  logic                        we,
    output logic [7:0]                  rdata,
    input  conv_res_t                   res,
    output logic                        mod_en,
    output logic [DIV_W-1:0]            div,
    output logic [NCH-1:0]              chan_en,
    output logic                        irq
);
    logic                          hold_en;
    logic [DIV_W-1:0]              div_q;
    logic [NCH-1:0][6:0]           ctrl_q;
    logic [NCH-1:0]                valid_q;
    logic [NCH-1:0][RES_W-1:0]     data_q;
    logic [NCH-1:0]                ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_en  <= 1'b0;
            hold_en <= 1'b0;
            div_q   <= '0;
        end else if (we && addr == ADDR_W'(A_CFG)) begin
            mod_en  <= wdata[0];
            hold_en <= wdata[1];
        end else if (we && addr == ADDR_W'(A_DIV)) begin
            div_q   <= wdata[DIV_W-1:0];
        end
    end

    for (genvar s = 0; s < NCH; s++) begin : g_slot
        logic clr_stat;
        logic clr;
        logic hit;

        if (s < NLOW) begin : g_idx
            assign chan_en[s] = (ctrl_q[s][4:0] == 5'(s));
        end else begin : g_bit
            assign chan_en[s] = ctrl_q[s][4];
        end

        if (s < NSTAT_A) begin : g_sa
            assign clr_stat = we && addr == ADDR_W'(A_STA) && wdata[s];
        end else begin : g_sb
            assign clr_stat = we && addr == ADDR_W'(A_STB) && wdata[s - NSTAT_A];
        end

        assign clr = clr_stat || (we && addr == ADDR_W'(A_CTRL0 + s) && wdata[7]);
        assign hit = res.fire && res.slot == SLOT_W'(s);
        assign ie[s] = ctrl_q[s][5];

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[s]  <= (s < NLOW) ? 7'h1F : 7'h00;
                valid_q[s] <= 1'b0;
                data_q[s]  <= '0;
            end else begin
                if (we && addr == ADDR_W'(A_CTRL0 + s))
                    ctrl_q[s] <= wdata[6:0];
                if (hit)      valid_q[s] <= 1'b1;   // new result wins over clear
                else if (clr) valid_q[s] <= 1'b0;
                if (hit && !(hold_en && valid_q[s]))
                    data_q[s] <= res.value;
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (addr == ADDR_W'(A_CFG)) rdata = {6'b0, hold_en, mod_en};
        if (addr == ADDR_W'(A_DIV)) rdata = 8'(div_q);
        if (addr == ADDR_W'(A_STA)) rdata = 8'(valid_q[NSTAT_A-1:0]);
        if (addr == ADDR_W'(A_STB)) rdata = 8'(valid_q[NCH-1:NSTAT_A]);
        for (int s = 0; s < NCH; s++) begin
            if (addr == ADDR_W'(A_CTRL0 + s))
                rdata = {valid_q[s], ctrl_q[s]};
            if (addr == ADDR_W'(A_DATA0 + 2*s))
                rdata = 8'(data_q[s][RES_W-1:8]);
            if (addr == ADDR_W'(A_DATA0 + 2*s + 1))
                rdata = data_q[s][7:0];
        end
    end

    assign div = div_q;
    assign irq = |(valid_q & ie & chan_en);
endmodule

// File: rtl/adc_fe_top.sv
module adc_fe_top
    import adc_fe_pkg::*;
#(
    parameter int BASE_CYC   = 4,
    parameter int SAMPLE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    output logic              conv_req,
    output logic [CHAN_W-1:0] conv_chan,
    input  logic              conv_ack,
    input  logic [RES_W-1:0]  conv_result,
    output logic              irq
);
    logic              mod_en;
    logic [DIV_W-1:0]  div;
    logic [NCH-1:0]    chan_en;
    logic [SLOT_W-1:0] cur_slot;
    conv_res_t         res;

    assign res.fire  = conv_req && conv_ack;
    assign res.slot  = cur_slot;
    assign res.value = conv_result;

    adc_fe_sched #(
        .BASE_CYC  (BASE_CYC),
        .SAMPLE_CYC(SAMPLE_CYC)
    ) i_sched (
        .clk      (clk),
        .rst      (rst),
        .mod_en   (mod_en),
        .chan_en  (chan_en),
        .div      (div),
        .conv_ack (conv_ack),
        .conv_req (conv_req),
        .conv_chan(conv_chan),
        .cur_slot (cur_slot)
    );

    adc_fe_regs i_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .we     (bus_we),
        .rdata  (bus_rdata),
        .res    (res),
        .mod_en (mod_en),
        .div    (div),
        .chan_en(chan_en),
        .irq    (irq)
    );
endmodule

// File: rtl/adc_fe_chk.sv
module adc_fe_conv_chk
    import adc_fe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic              mod_en,
    input logic              conv_req,
    input logic              conv_ack,
    input logic [CHAN_W-1:0] conv_chan,
    input logic              irq
);
    // R4: module off for two cycles means no request
    a_r4_no_req_when_off: assert property (@(posedge clk) disable iff (rst)
        (!mod_en && !$past(mod_en)) |-> !conv_req);

    // R3: only existing logical channel numbers are requested
    a_r3_legal_chan: assert property (@(posedge clk) disable iff (rst)
        conv_req |-> (conv_chan < 5'd8 || (conv_chan >= 5'd13 && conv_chan <= 5'd16)));

    // R12: request held with a stable channel until acknowledged
    a_r12_req_held: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_ack && mod_en) |=> (conv_req && $stable(conv_chan)));

    // R10: the interrupt only rises after an accepted result or a register write
    a_r10_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(conv_req && conv_ack) || $past(bus_we)));
endmodule

module adc_fe_reg_chk
    import adc_fe_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    we,
    input logic                    hold_en,
    input logic [NCH-1:0]          valid_q,
    input logic [NCH-1:0][RES_W-1:0] data_q
);
    // R8: a valid flag only drops after a bus write
    a_r8_clear_by_write: assert property (@(posedge clk) disable iff (rst)
        (|($past(valid_q) & ~valid_q)) |-> $past(we));

    for (genvar s = 0; s < NCH; s++) begin : g_hold
        // R9: held data does not move while its flag is set
        a_r9_hold_frozen: assert property (@(posedge clk) disable iff (rst)
            $past(hold_en && valid_q[s]) |-> $stable(data_q[s]));
    end
endmodule

bind adc_fe_top adc_fe_conv_chk u_conv_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .mod_en   (mod_en),
    .conv_req (conv_req),
    .conv_ack (conv_ack),
    .conv_chan(conv_chan),
    .irq      (irq)
);

bind adc_fe_regs adc_fe_reg_chk u_reg_chk (
    .clk    (clk),
    .rst    (rst),
    .we     (we),
    .hold_en(hold_en),
    .valid_q(valid_q),
    .data_q (data_q)
);

// File: tb/test_adc_fe_top.sv
module test_adc_fe_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BASE   = 4;
    localparam int SAMPLE = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       conv_req;
    logic [4:0] conv_chan;
    logic       conv_ack;
    logic [9:0] conv_result;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    int n_conv = 0;
    int ack_lat = 0;
    int req_age = 0;
    logic [9:0] salt = 10'h000;
    logic [4:0] clog [0:63];

    always #2.5 clk = ~clk;

    adc_fe_top #(.BASE_CYC(BASE), .SAMPLE_CYC(SAMPLE)) i_adc_fe_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .conv_req(conv_req),
        .conv_chan(conv_chan), .conv_ack(conv_ack), .conv_result(conv_result),
        .irq(irq)
    );

    function automatic logic [9:0] model(input logic [4:0] ch, input logic [9:0] s);
        return 10'(int'(ch) * 41) + s;
    endfunction

    // converter model
    assign conv_ack    = conv_req && (req_age >= ack_lat);
    assign conv_result = model(conv_chan, salt);

    always @(posedge clk) begin
        req_age <= (conv_req && !conv_ack) ? req_age + 1 : 0;
        if (rst) n_conv <= 0;
        else if (conv_req && conv_ack) begin
            clog[n_conv % 64] <= conv_chan;
            n_conv <= n_conv + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 6'(a); bus_wdata = 8'(d); bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_addr = 6'(a);
        #0.001;
        d = int'(bus_rdata);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_conv(input int k);
        int target;
        target = n_conv + k;
        while (n_conv < target) @(negedge clk);
    endtask

    task automatic gap(output int g);
        while (!conv_req) @(negedge clk);
        while (conv_req) @(negedge clk);
        g = 0;
        while (!conv_req) begin g++; @(negedge clk); end
    endtask

    task automatic t_reset();
        int d;
        do_reset();
        rd(0, d);  chk("R1 cfg", d, 0);
        rd(1, d);  chk("R1 div", d, 0);
        rd(2, d);  chk("R1 status a", d, 0);
        rd(3, d);  chk("R1 status b", d, 0);
        rd(4, d);  chk("R1 ctrl slot0", d, 8'h1F);
        rd(7, d);  chk("R1 ctrl slot3", d, 8'h1F);
        rd(9, d);  chk("R1 ctrl slot5", d, 0);
        rd(16, d); chk("R1 data hi slot0", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 req", conv_req, 0);
    endtask

    task automatic t_enable_gate();
        int seen;
        do_reset();
        wr(6, 8'h02);
        seen = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (conv_req) seen++; end
        chk("R4 no request while module off", seen, 0);
        wr(0, 1);
        wait_conv(1);
        wr(0, 0);
        chk("R4 request after enable", n_conv > 0, 1);
    endtask

    task automatic t_low_select();
        int base;
        do_reset();
        wr(6, 8'h02); wr(5, 8'h02);      // slot2 own index, slot1 wrong index
        base = n_conv;
        wr(0, 1);
        wait_conv(3);
        wr(0, 0);
        for (int i = 0; i < 3; i++) chk("R2 only slot2 serviced", clog[base + i], 2);
        wr(6, 8'h1F); wr(5, 8'h01);
        base = n_conv;
        wr(0, 1);
        wait_conv(2);
        wr(0, 0);
        for (int i = 0; i < 2; i++) chk("R2 deselect 0x1F, slot1 own index", clog[base + i], 1);
    endtask

    task automatic t_timing();
        int g;
        do_reset();
        wr(8, 8'h10);
        wr(1, 1);
        wr(0, 1);
        gap(g); gap(g);
        chk("R5 gap div=1", g, SAMPLE + 2 * BASE);
        wr(1, 0);
        gap(g); gap(g);
        chk("R5 gap div=0", g, SAMPLE + BASE);
        wr(1, 63);
        gap(g); gap(g);
        chk("R5 gap div=63", g, SAMPLE + 64 * BASE);
        wr(0, 0);
    endtask

    task automatic t_round_robin();
        int d;
        int exp_seq [6] = '{0, 5, 14, 16, 0, 5};
        logic [9:0] r;
        do_reset();
        salt = 10'h300;
        wr(4, 8'h00); wr(9, 8'h10); wr(13, 8'h10); wr(15, 8'h10);
        wr(0, 1);
        wait_conv(8);
        wr(0, 0);
        for (int i = 0; i < 6; i++) chk("R6 R3 service order", clog[i], exp_seq[i]);
        rd(2, d); chk("R11 status a", d, 8'h21);
        rd(3, d); chk("R11 status b", d, 8'h0A);
        r = model(5'd16, salt);
        rd(16 + 22, d); chk("R7 data hi slot11", d, int'(r[9:8]));
        rd(16 + 23, d); chk("R7 data lo slot11", d, int'(r[7:0]));
        rd(9, d); chk("R7 ctrl slot5 flag", d, 8'h90);
        // W1C
        wr(2, 8'h01); rd(2, d); chk("R8 status clear bit0", d, 8'h20);
        wr(2, 8'h00); rd(2, d); chk("R8 zero write no effect", d, 8'h20);
        wr(9, 8'h90); rd(2, d); chk("R8 control bit7 clear", d, 8'h00);
        rd(9, d); chk("R8 control keeps select", d, 8'h10);
        wr(3, 8'h0A); rd(3, d); chk("R8 status b clear", d, 8'h00);
    endtask

    task automatic t_hold();
        int d;
        logic [9:0] a_val;
        logic [9:0] b_val;
        do_reset();
        wr(6, 8'h02);
        salt = 10'h155;
        a_val = model(5'd2, 10'h155);
        wr(0, 3);
        wait_conv(1);
        salt = 10'h2AA;
        b_val = model(5'd2, 10'h2AA);
        wait_conv(2);
        wr(0, 0);
        rd(20, d); chk("R9 held hi", d, int'(a_val[9:8]));
        rd(21, d); chk("R9 held lo", d, int'(a_val[7:0]));
        wr(2, 8'h04);
        wr(0, 3);
        wait_conv(1);
        wr(0, 0);
        rd(21, d); chk("R9 refresh after clear", d, int'(b_val[7:0]));
        salt = 10'h0F0;
        wr(0, 1);
        wait_conv(1);
        salt = 10'h3C3;
        b_val = model(5'd2, 10'h3C3);
        wait_conv(1);
        wr(0, 0);
        rd(20, d); chk("R9 no hold overwrite hi", d, int'(b_val[9:8]));
        rd(21, d); chk("R9 no hold overwrite lo", d, int'(b_val[7:0]));
    endtask

    task automatic t_irq();
        int d;
        do_reset();
        wr(10, 8'h30);
        wr(0, 1);
        wait_conv(1);
        wr(0, 0);
        @(negedge clk);
        chk("R10 irq on valid+ie", irq, 1);
        wr(10, 8'h30);
        chk("R10 irq held without clear", irq, 1);
        wr(2, 8'h40);
        chk("R10 irq drops on clear", irq, 0);
        wr(10, 8'h10);
        wr(0, 1);
        wait_conv(1);
        wr(0, 0);
        rd(2, d); chk("R10 flag set ie off", d, 8'h40);
        chk("R10 no irq ie off", irq, 0);
        wr(10, 8'h30);
        chk("R10 irq when ie set late", irq, 1);
        wr(10, 8'h20);
        chk("R10 no irq when deselected", irq, 0);
    endtask

    task automatic t_handshake();
        int hi;
        do_reset();
        ack_lat = 3;
        wr(7, 8'h03);
        wr(0, 1);
        while (!conv_req) @(negedge clk);
        hi = 0;
        while (conv_req) begin
            chk("R12 channel stable", conv_chan, 3);
            hi++;
            @(negedge clk);
        end
        chk("R12 request held until ack", hi, 4);
        wr(0, 0);
        ack_lat = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_enable_gate();
        t_low_select();
        t_timing();
        t_round_robin();
        t_hold();
        t_irq();
        t_handshake();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule